// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block watches the command strobes sent to a two-bank synchronous DRAM. It keeps a model of each bank's state and checks every command against that state. When a command arrives that the memory must not receive in its current state, the block raises `illegal` in the same cycle. An illegal command does not change the model. Legal commands, and the expiry of the recovery timers, move the per-bank state forward. The current state of every bank is exported, so a controller or a protocol monitor can see the memory's condition at any time.

The block does not schedule anything itself. Three intervals are counted in clock cycles set by parameters:

- write recovery, before a bank may return to active or start precharging;
- the precharge interval;
- the refresh cycle.

The mode-register window lasts a fixed number of cycles. Commands are only judged when the clock-enable input was high in the previous cycle. Power down is modelled as a device-wide state.

Top module: `sdr_bank_checker`

## Requirements
- R1: After reset, every bank reads idle and `illegal` is low.
- R2: Commands are decoded from {cs_n, ras_n, cas_n, we_n}:
  - cs_n high is deselect;
  - 0111 is no-op;
  - 0110 is burst stop;
  - 0101 is read;
  - 0100 is write;
  - 0011 is activate;
  - 0010 is precharge, where a10=1 means all banks;
  - 0001 is refresh;
  - 0000 is mode-register set.

  Bank state codes are 3 bits: 0 idle, 1 active, 2 write recovery, 3 write recovery with auto precharge, 4 precharging, 5 refreshing, 6 mode-register window, 7 power down. Bank i occupies `bank_state[3i+2:3i]`.
- R3: `illegal` is high combinationally in the cycle of an offending command. An illegal command leaves the state as a no-op would; timers keep running.
- R4: In idle, read and write are illegal, activate goes to active, and precharge is accepted with no state change. In active, activate is illegal. A read with a10=1 goes to precharging. A write goes to write recovery, or to write recovery with auto precharge if a10=1. Precharge goes to precharging. Precharging returns to idle after TRP cycles.
- R5: Write recovery absorbs deselect, no-op and burst stop. It returns to active after TDPL cycles in that state.
- R6: During write recovery, a read to that bank is legal and is handled as from active. A write to that bank is legal and restarts recovery, with a10 choosing auto precharge. Activate and precharge to that bank are illegal.
- R7: During write recovery with auto precharge, read, write, activate and precharge to that bank are illegal. After TDPL cycles the bank goes to precharging, and then to idle after TRP cycles.
- R8: A bank-addressed command is judged only against the state of the bank selected by `ba`.
- R9: Refresh is legal only when every bank is idle. It puts every bank into refreshing for TRC cycles. While refreshing, every command other than deselect, no-op and burst stop is illegal.
- R10: A legal mode-register set is accepted only when every bank is idle. It holds every bank in the mode-register window for exactly TMRD (2) cycles. Every command other than deselect, no-op and burst stop is illegal in that window.
- R11: When `cke` was low in the previous cycle, the command is ignored and `illegal` stays low.
- R12: With `cke` low and every bank idle, all banks enter power down in the next cycle. They leave it for idle in the cycle after `cke` is seen high. `cke` low while any bank is busy does not enter power down.
- R13: Precharge-all is legal only if every bank is idle or active. If so, every active bank goes to precharging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select strobe |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable strobe |
| cke | input | 1 | Clock enable |
| ba | input | $clog2(NBANK) | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks select |
| illegal | output | 1 | Offending command this cycle |
| bank_state | output | 3*NBANK | Packed per-bank state codes |

## Verification
The bench targets the timer edges:

- The exact cycle in which write recovery hands back to active or to precharging. A design off by one would show the wrong state one cycle early or late.
- A mode-register window that is two cycles long, not one or three.

It also covers cross-bank cases:

- A read to an active bank while the other bank is in auto-precharge recovery must pass. A design that judged the wrong bank would flag it.
- A precharge-all during that recovery must be rejected without disturbing the running timers.

Finally it tests the clock-enable lag. A command in the cycle after cke rises must be ignored. A design that used the current cke would flag it or change state.

// File: rtl/sdr_chk_pkg.sv
// Package: shared command and bank-state types for the SDRAM legality monitor.
// Assumes: two-bank device, commands sampled on every rising clock edge.
package sdr_chk_pkg;

    typedef enum logic [3:0] {
        C_DESL, C_NOP, C_BST, C_READ, C_WRIT, C_ACT, C_PRE, C_REF, C_MRS
    } sdr_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_WREC   = 3'd2,
        ST_WRECAP = 3'd3,
        ST_PRECHG = 3'd4,
        ST_REFR   = 3'd5,
        ST_MODE   = 3'd6,
        ST_PDOWN  = 3'd7
    } bank_st_t;

    localparam int ST_W = 3;

endpackage

// File: rtl/sdr_cmd_decode.sv
// Module: sdr_cmd_decode
// Turns the four command strobes into a command code.
// Assumes: strobes are active low and already synchronous to the clock.
module sdr_cmd_decode
    import sdr_chk_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdr_cmd_t cmd
);

    // Purpose: map the strobe pattern to the command it encodes.
    always_comb begin
        if (cs_n) begin
            cmd = C_DESL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = C_NOP;
                3'b110:  cmd = C_BST;
                3'b101:  cmd = C_READ;
                3'b100:  cmd = C_WRIT;
                3'b011:  cmd = C_ACT;
                3'b010:  cmd = C_PRE;
                3'b001:  cmd = C_REF;
                default: cmd = C_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdr_bank_track.sv
// Module: sdr_bank_track
// Holds one bank's state and recovery counter, and judges whether the current
// command is legal for this bank.
// Assumes: the top decides 'apply' (command accepted) and the device-wide
// events (refresh, mode set, power down entry); this block only follows them.
module sdr_bank_track
    import sdr_chk_pkg::*;
#(
    parameter int IDX  = 0,
    parameter int BAW  = 1,
    parameter int CW   = 4,
    parameter int TDPL = 2,
    parameter int TRP  = 3,
    parameter int TRC  = 8,
    parameter int TMRD = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  sdr_cmd_t       cmd,
    input  logic [BAW-1:0] ba,
    input  logic           a10,
    input  logic           apply,
    input  logic           go_ref,
    input  logic           go_mrs,
    input  logic           go_pd,
    input  logic           cke,
    output bank_st_t       state,
    output logic           ill
);

    logic [CW-1:0] cnt;
    logic          hit;
    logic          noop;
    logic          timed;

    // Purpose: is this bank the target of the present command.
    always_comb begin
        hit  = ((cmd == C_PRE) && a10) || (ba == BAW'(IDX));
        noop = (cmd == C_DESL) || (cmd == C_NOP) || (cmd == C_BST);
        timed = (state == ST_WREC) || (state == ST_WRECAP) || (state == ST_PRECHG)
              || (state == ST_REFR) || (state == ST_MODE);
    end

    // Purpose: legality of the present command as seen from this bank.
    always_comb begin
        ill = 1'b0;
        if ((state == ST_REFR) || (state == ST_MODE)) begin
            ill = !noop;
        end else if (state == ST_PDOWN) begin
            ill = 1'b0;
        end else if ((cmd == C_REF) || (cmd == C_MRS)) begin
            ill = (state != ST_IDLE);
        end else if (hit && !noop) begin
            case (state)
                ST_IDLE:   ill = (cmd == C_READ) || (cmd == C_WRIT);
                ST_ACTIVE: ill = (cmd == C_ACT);
                ST_WREC:   ill = (cmd == C_ACT) || (cmd == C_PRE);
                default:   ill = 1'b1;
            endcase
        end
    end

    // Purpose: advance the bank state and its recovery counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (go_pd) begin
            state <= ST_PDOWN;
        end else if (state == ST_PDOWN) begin
            if (cke) state <= ST_IDLE;
        end else if (go_ref) begin
            state <= ST_REFR;
            cnt   <= CW'(TRC - 1);
        end else if (go_mrs) begin
            state <= ST_MODE;
            cnt   <= CW'(TMRD - 1);
        end else if (apply && hit && !noop) begin
            case (cmd)
                C_ACT: state <= ST_ACTIVE;
                C_READ: begin
                    if (a10) begin
                        state <= ST_PRECHG;
                        cnt   <= CW'(TRP - 1);
                    end else begin
                        state <= ST_ACTIVE;
                    end
                end
                C_WRIT: begin
                    state <= a10 ? ST_WRECAP : ST_WREC;
                    cnt   <= CW'(TDPL - 1);
                end
                C_PRE: begin
                    if (state == ST_ACTIVE) begin
                        state <= ST_PRECHG;
                        cnt   <= CW'(TRP - 1);
                    end
                end
                default: state <= state;
            endcase
        end else if (timed) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                case (state)
                    ST_WREC:   state <= ST_ACTIVE;
                    ST_WRECAP: begin
                        state <= ST_PRECHG;
                        cnt   <= CW'(TRP - 1);
                    end
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdr_bank_checker.sv
// Module: sdr_bank_checker (top)
// Decodes each command, asks every bank tracker whether it is legal, raises
// 'illegal' in the same cycle and steers device-wide state changes.
// Assumes: commands are judged only when cke was high in the previous cycle.
module sdr_bank_checker
    import sdr_chk_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int TDPL  = 2,
    parameter int TRP   = 3,
    parameter int TRC   = 8,
    parameter int TMRD  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic                       cke,
    input  logic [$clog2(NBANK)-1:0]   ba,
    input  logic                       a10,
    output logic                       illegal,
    output logic [NBANK*ST_W-1:0]      bank_state
);

    localparam int BAW  = $clog2(NBANK);
    localparam int TM1  = (TDPL > TRP) ? TDPL : TRP;
    localparam int TM2  = (TRC > TMRD) ? TRC : TMRD;
    localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
    localparam int CW   = $clog2(TMAX + 1);

    sdr_cmd_t         cmd;
    logic             cke_q;
    logic [NBANK-1:0] bank_ill;
    logic [NBANK-1:0] bank_idle;
    logic             all_idle;
    logic             apply;
    logic             go_ref;
    logic             go_mrs;
    logic             go_pd;
    bank_st_t         st [NBANK];

    sdr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    // Purpose: remember last cycle's clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    // Purpose: combine per-bank verdicts into the flag and device events.
    always_comb begin
        all_idle = &bank_idle;
        illegal  = cke_q && (|bank_ill);
        apply    = cke_q && !(|bank_ill);
        go_ref   = apply && (cmd == C_REF);
        go_mrs   = apply && (cmd == C_MRS);
        go_pd    = !cke && all_idle;
    end

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        sdr_bank_track #(
            .IDX (i), .BAW (BAW), .CW (CW),
            .TDPL(TDPL), .TRP(TRP), .TRC(TRC), .TMRD(TMRD)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd    (cmd),
            .ba     (ba),
            .a10    (a10),
            .apply  (apply),
            .go_ref (go_ref),
            .go_mrs (go_mrs),
            .go_pd  (go_pd),
            .cke    (cke),
            .state  (st[i]),
            .ill    (bank_ill[i])
        );
        assign bank_idle[i] = (st[i] == ST_IDLE);
        assign bank_state[i*ST_W +: ST_W] = st[i];
    end

endmodule

// File: rtl/sdr_bank_checker_sva.sv
// Module: sdr_bank_checker_sva
// Protocol assertions for the legality monitor, bound to the top.
// Assumes: NBANK >= 1; mode window length TMRD fits in 8 bits.
module sdr_bank_checker_sva
    import sdr_chk_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int TMRD  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cke,
    input logic                  cke_q,
    input logic                  illegal,
    input logic [NBANK*ST_W-1:0] bank_state
);

    logic [NBANK-1:0] is_idle;
    logic [NBANK-1:0] is_pd;
    logic [NBANK-1:0] is_steady;
    logic [7:0]       mode_run;
    logic [ST_W-1:0]  st0;

    assign st0 = bank_state[ST_W-1:0];

    for (genvar i = 0; i < NBANK; i++) begin : g_cls
        assign is_idle[i]   = bank_state[i*ST_W +: ST_W] == ST_IDLE;
        assign is_pd[i]     = bank_state[i*ST_W +: ST_W] == ST_PDOWN;
        assign is_steady[i] = is_idle[i] || (bank_state[i*ST_W +: ST_W] == ST_ACTIVE);
    end

    // Purpose: count consecutive cycles bank 0 has spent in the mode window.
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_run <= '0;
        else if (st0 == ST_MODE) mode_run <= mode_run + 8'd1;
        else                     mode_run <= '0;
    end

    AST_NO_FLAG_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |-> !illegal);                                             // R11

    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && cke && (&is_steady)) |=> $stable(bank_state));        // R3

    AST_MODE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (st0 == ST_MODE) |-> (mode_run < 8'(TMRD)));                      // R10

    AST_MODE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st0 != ST_MODE) && (mode_run != 8'd0)) |-> (mode_run == 8'(TMRD))); // R10

    AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && (&is_idle)) |=> (&is_pd));                               // R12

    for (genvar i = 0; i < NBANK; i++) begin : g_bank_props
        AST_SHARED_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            ((bank_state[i*ST_W +: ST_W] == ST_REFR) || (bank_state[i*ST_W +: ST_W] == ST_MODE)
             || (bank_state[i*ST_W +: ST_W] == ST_PDOWN))
            |-> (bank_state[i*ST_W +: ST_W] == st0));                     // R9

        AST_APWR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_state[i*ST_W +: ST_W] == ST_WRECAP)
            |=> ((bank_state[i*ST_W +: ST_W] == ST_WRECAP)
                 || (bank_state[i*ST_W +: ST_W] == ST_PRECHG)));          // R7
    end

endmodule

bind sdr_bank_checker sdr_bank_checker_sva #(
    .NBANK (NBANK),
    .TMRD  (TMRD)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cke_q      (cke_q),
    .illegal    (illegal),
    .bank_state (bank_state)
);

// File: tb/sdr_bank_checker_tb.sv
// Scoreboard bench: the driver queues the expected flag and states, the
// monitor pops and compares them as the design responds.
module sdr_bank_checker_tb;

    localparam logic [3:0] K_DESL = 4'b1111, K_NOP = 4'b0111, K_BST = 4'b0110,
                           K_READ = 4'b0101, K_WRIT = 4'b0100, K_ACT = 4'b0011,
                           K_PRE  = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       cke = 1'b1;
    logic [0:0] ba = '0;
    logic       a10 = 1'b0;
    logic       illegal;
    logic [5:0] bank_state;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] q_exp [$];
    string      q_tag [$];

    always #5 clk = ~clk;

    sdr_bank_checker #(
        .NBANK(2), .TDPL(2), .TRP(2), .TRC(3), .TMRD(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
        .illegal(illegal), .bank_state(bank_state)
    );

    // Driver: apply one command for one cycle and queue what must follow.
    task automatic issue(input logic [3:0] k, input logic b, input logic a,
                         input logic ck, input logic e_ill,
                         input logic [2:0] e0, input logic [2:0] e1,
                         input string tag);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = k;
        ba  = b;
        a10 = a;
        cke = ck;
        q_exp.push_back({e_ill, e1, e0});
        q_tag.push_back(tag);
    endtask

    // Monitor: flag mid-cycle, states just after the following edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q_exp.size() > 0) begin
                logic [6:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_chk++;
                if (illegal !== e[6]) begin
                    n_bad++;
                    $display("FAIL %s illegal: got %b expected %b", t, illegal, e[6]);
                end
                @(posedge clk);
                #1;
                n_chk++;
                if (bank_state !== e[5:0]) begin
                    n_bad++;
                    $display("FAIL %s states {b1,b0}: got %0d,%0d expected %0d,%0d", t,
                             bank_state[5:3], bank_state[2:0], e[5:3], e[2:0]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        issue(K_NOP,  0, 0, 1, 0, 0, 0, "R1 reset idle");
        issue(K_READ, 0, 0, 1, 1, 0, 0, "R3 R4 read to idle");
        issue(K_MRS,  0, 0, 1, 0, 6, 6, "R10 mode set");
        issue(K_ACT,  0, 0, 1, 1, 6, 6, "R10 act in mode window");
        issue(K_NOP,  0, 0, 1, 0, 0, 0, "R10 window ends after 2");
        issue(K_ACT,  0, 0, 1, 0, 1, 0, "R4 act bank0");
        issue(K_ACT,  1, 0, 1, 0, 1, 1, "R4 R8 act bank1");
        issue(K_ACT,  0, 0, 1, 1, 1, 1, "R4 act to active");
        issue(K_WRIT, 0, 0, 1, 0, 2, 1, "R5 write");
        issue(K_BST,  0, 0, 1, 0, 2, 1, "R2 R5 bst no-op");
        issue(K_DESL, 0, 0, 1, 0, 1, 1, "R2 R5 back to active");
        issue(K_WRIT, 0, 0, 1, 0, 2, 1, "R5 write again");
        issue(K_READ, 0, 0, 1, 0, 1, 1, "R6 read in recovery");
        issue(K_WRIT, 0, 0, 1, 0, 2, 1, "R6 write");
        issue(K_WRIT, 0, 1, 1, 0, 3, 1, "R6 write with ap in recovery");
        issue(K_READ, 0, 0, 1, 1, 3, 1, "R7 read same bank");
        issue(K_READ, 1, 0, 1, 0, 4, 1, "R7 R8 read other bank");
        issue(K_ACT,  0, 0, 1, 1, 4, 1, "R7 act while precharging");
        issue(K_NOP,  0, 0, 1, 0, 0, 1, "R7 precharge done");
        issue(K_PRE,  1, 0, 1, 0, 0, 4, "R4 precharge bank1");
        issue(K_NOP,  0, 0, 1, 0, 0, 4, "R4 precharging");
        issue(K_NOP,  0, 0, 1, 0, 0, 0, "R4 idle");
        issue(K_REF,  0, 0, 1, 0, 5, 5, "R9 refresh");
        issue(K_PRE,  0, 1, 1, 1, 5, 5, "R9 pall in refresh");
        issue(K_MRS,  0, 0, 1, 1, 5, 5, "R9 mrs in refresh");
        issue(K_NOP,  0, 0, 1, 0, 0, 0, "R9 refresh done");
        issue(K_NOP,  0, 0, 0, 0, 7, 7, "R12 power down");
        issue(K_READ, 0, 0, 0, 0, 7, 7, "R11 ignored in pd");
        issue(K_READ, 0, 0, 1, 0, 0, 0, "R11 R12 wake, ignored");
        issue(K_READ, 0, 0, 1, 1, 0, 0, "R3 judged again");
        issue(K_ACT,  0, 0, 1, 0, 1, 0, "R4 act bank0");
        issue(K_ACT,  1, 0, 1, 0, 1, 1, "R4 act bank1");
        issue(K_PRE,  0, 1, 1, 0, 4, 4, "R13 pall legal");
        issue(K_NOP,  0, 0, 1, 0, 4, 4, "R13 precharging");
        issue(K_NOP,  0, 0, 1, 0, 0, 0, "R13 idle");
        issue(K_ACT,  0, 0, 1, 0, 1, 0, "R4 act bank0");
        issue(K_NOP,  0, 0, 0, 0, 1, 0, "R12 busy no pd");
        issue(K_ACT,  1, 0, 1, 0, 1, 0, "R11 act ignored");
        issue(K_ACT,  1, 0, 1, 0, 1, 1, "R4 act bank1");
        issue(K_REF,  0, 0, 1, 1, 1, 1, "R9 refresh not idle");
        issue(K_WRIT, 0, 1, 1, 0, 3, 1, "R7 writea bank0");
        issue(K_WRIT, 1, 0, 1, 0, 3, 2, "R8 write other bank");
        issue(K_PRE,  0, 1, 1, 1, 4, 2, "R13 pall illegal");
        issue(K_NOP,  0, 0, 1, 0, 4, 1, "R5 R7 timers");
        issue(K_NOP,  0, 0, 1, 0, 0, 1, "R7 idle");
        issue(K_READ, 1, 1, 1, 0, 0, 4, "R4 reada");
        issue(K_NOP,  0, 0, 1, 0, 0, 4, "R4 precharging");
        issue(K_NOP,  0, 0, 1, 0, 0, 0, "R4 idle");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule